// File: doc/BRIEF.md
# Serial Configuration Write Port

This block takes 8-bit configuration words from a three-wire serial link and stores them in a small register file. The three wires are an active-low select, a serial clock and a data line. The register file drives the settings of a multi-channel serialising converter: the output pattern choice, the data-lane drive-current code, the bit order, doubling of the clock-lane drive, one power-down bit per channel and a 12-bit user pattern. The link can only write, so nothing is read back.

Each word is shifted in on rising serial-clock edges while the select line is low. The top four bits are an address and the bottom four bits are data. The select line is carried into the sample-clock domain through a synchronizer. On its rising edge a word is committed, but only when exactly eight bits were shifted. Because the shifter is idle while select is high, the shifted word and its bit count do not move at the moment they are read. That lets them be copied across the clock boundary without a handshake. Every register output therefore changes at one known sample-clock edge.

Top module: `cfg_serial_port`

## Requirements
- R1: While `rst_n` is low, every register output is 0. The same holds right after reset is released, until the first committed word.
- R2: A word is sent most-significant bit first. The first four bits form the address and the last four bits form the data.
- R3: A committed word appears on the outputs at the third rising edge of `clk` after `csn` rises, and no earlier. The outputs change at no other time.
- R4: A frame in which the number of rising `sclk` edges while `csn` is low differs from 8 (for example 7 or 9) changes no output.
- R5: Writes to addresses 7 to 15 change no output.
- R6: Address 0 sets `pat_sel` from data bits 3..2 and `drv_code` from data bits 1..0.
- R7: Address 1 sets `msb_first` from data bit 2 and `clk_drv_dbl` from data bit 0. Data bits 3 and 1 are ignored.
- R8: Address 2 sets `pd_mask[3:0]` and address 3 sets `pd_mask[7:4]`. Data bit 0 maps to the lowest channel of each group.
- R9: Addresses 4, 5 and 6 set `cust_pat[3:0]`, `cust_pat[7:4]` and `cust_pat[11:8]`, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all register outputs are updated on it |
| rst_n | input | 1 | Asynchronous reset, active low; clears every register |
| csn | input | 1 | Serial select, active low; its rising edge ends a frame |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdin | input | 1 | Serial data, most-significant bit first |
| pat_sel | output | 2 | Output pattern choice |
| drv_code | output | 2 | Data-lane drive-current code |
| msb_first | output | 1 | 1 = send words most-significant bit first |
| clk_drv_dbl | output | 1 | 1 = double the clock-lane drive current |
| pd_mask | output | 8 | Power-down bit per channel; bit 0 is channel 1 |
| cust_pat | output | 12 | User-defined 12-bit pattern |

## Verification
The bench uses the default parameters: a 4-bit address, 4-bit data, eight channels, a 12-bit pattern and two synchronizer stages. With these settings the whole word space is only 256 values, so every address is swept with every data value. Expected outputs come from an arithmetic model of the address map. Each commit is checked twice: the outputs must still hold the old values two sample edges after select rises, and must hold the new values one edge later. Short and long frames, and a reset applied in the middle of the run, are covered as well.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   // fixed addresses of the control words; later groups follow from parameters
   localparam int unsigned ADDR_MODE  = 0;
   localparam int unsigned ADDR_ORDER = 1;
   localparam int unsigned ADDR_PD    = 2;

   // field positions inside a data nibble
   localparam int unsigned PAT_HI   = 3;
   localparam int unsigned PAT_LO   = 2;
   localparam int unsigned DRV_HI   = 1;
   localparam int unsigned DRV_LO   = 0;
   localparam int unsigned ORD_BIT  = 2;
   localparam int unsigned DBL_BIT  = 0;

   typedef struct packed {
      logic [1:0] pat_sel;
      logic [1:0] drv_code;
      logic       msb_first;
      logic       clk_dbl;
   } cfg_ctl_t;

endpackage

// File: rtl/cfg_shift.sv
module cfg_shift #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sdin,
   output logic [WORD_W-1:0] word,
   output logic              word_ok
);
   localparam int unsigned CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0] cnt;
   logic             cnt_clr;

   // the edge counter restarts whenever the link is deselected
   assign cnt_clr = ~rst_n | csn;

   always_ff @(posedge sclk or posedge cnt_clr) begin
      if (cnt_clr)
         cnt <= '0;
      else if (cnt != CNT_SAT)
         cnt <= cnt + 1'b1;
   end

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         word    <= '0;
         word_ok <= 1'b0;
      end else if (!csn) begin
         word    <= {word[WORD_W-2:0], sdin};
         word_ok <= (cnt == CNT_LAST);
      end
   end

endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csn,
   output logic commit
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= csn;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], csn};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   assign commit = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cfg_port_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 4,
   parameter int unsigned PD_GROUPS  = 2,
   parameter int unsigned PAT_GROUPS = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   output cfg_ctl_t                       ctl,
   output logic [PD_GROUPS*DATA_W-1:0]    pd_mask,
   output logic [PAT_GROUPS*DATA_W-1:0]   pat
);
   localparam int unsigned PAT_BASE = ADDR_PD + PD_GROUPS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADDR_MODE)) begin
            ctl.pat_sel  <= wr_data[PAT_HI:PAT_LO];
            ctl.drv_code <= wr_data[DRV_HI:DRV_LO];
         end
         if (wr_addr == ADDR_W'(ADDR_ORDER)) begin
            ctl.msb_first <= wr_data[ORD_BIT];
            ctl.clk_dbl   <= wr_data[DBL_BIT];
         end
      end
   end

   generate
      for (genvar g = 0; g < PD_GROUPS; g++) begin : g_pd
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(ADDR_PD + g))
               q <= wr_data;
         end
         assign pd_mask[g*DATA_W +: DATA_W] = q;
      end

      for (genvar g = 0; g < PAT_GROUPS; g++) begin : g_pat
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(PAT_BASE + g))
               q <= wr_data;
         end
         assign pat[g*DATA_W +: DATA_W] = q;
      end
   endgenerate

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned PAT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sclk,
   input  logic              sdin,
   output logic [1:0]        pat_sel,
   output logic [1:0]        drv_code,
   output logic              msb_first,
   output logic              clk_drv_dbl,
   output logic [NUM_CH-1:0] pd_mask,
   output logic [PAT_W-1:0]  cust_pat
);
   localparam int unsigned WORD_W     = ADDR_W + DATA_W;
   localparam int unsigned PD_GROUPS  = NUM_CH / DATA_W;
   localparam int unsigned PAT_GROUPS = PAT_W / DATA_W;
   localparam int unsigned USED_ADDR  = ADDR_PD + PD_GROUPS + PAT_GROUPS;

   generate
      if (DATA_W != 4) begin : g_bad_data
         $error("cfg_serial_port: field layout needs 4-bit data");
      end
      if (NUM_CH % DATA_W != 0 || PAT_W % DATA_W != 0) begin : g_bad_split
         $error("cfg_serial_port: mask and pattern must split into whole nibbles");
      end
      if (USED_ADDR > (1 << ADDR_W)) begin : g_bad_addr
         $error("cfg_serial_port: address field too narrow for the map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cfg_serial_port: at least two synchronizer stages required");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              word_ok;
   logic              commit;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   cfg_ctl_t          ctl;

   cfg_shift #(.WORD_W(WORD_W)) u_shift (
      .sclk    (sclk),
      .rst_n   (rst_n),
      .csn     (csn),
      .sdin    (sdin),
      .word    (word),
      .word_ok (word_ok)
   );

   cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .csn    (csn),
      .commit (commit)
   );

   // word and word_ok are static while csn is high, so they are read directly
   assign wr_en   = commit & word_ok;
   assign wr_addr = word[WORD_W-1:DATA_W];
   assign wr_data = word[DATA_W-1:0];

   cfg_regfile #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .PD_GROUPS  (PD_GROUPS),
      .PAT_GROUPS (PAT_GROUPS)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ctl     (ctl),
      .pd_mask (pd_mask),
      .pat     (cust_pat)
   );

   assign pat_sel     = ctl.pat_sel;
   assign drv_code    = ctl.drv_code;
   assign msb_first   = ctl.msb_first;
   assign clk_drv_dbl = ctl.clk_dbl;

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 4,
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned PAT_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csn,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [1:0]        pat_sel,
   input logic [1:0]        drv_code,
   input logic              msb_first,
   input logic              clk_drv_dbl,
   input logic [NUM_CH-1:0] pd_mask,
   input logic [PAT_W-1:0]  cust_pat
);
   localparam int unsigned FIRST_FREE = 2 + NUM_CH / DATA_W + PAT_W / DATA_W;
   localparam int unsigned PAT_BASE   = 2 + NUM_CH / DATA_W;

   logic [NUM_CH+PAT_W+5:0] all_out;
   assign all_out = {pat_sel, drv_code, msb_first, clk_drv_dbl, pd_mask, cust_pat};

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> all_out == '0);

   p_hold_between_commits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(all_out));

   p_commit_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> csn);

   p_free_addr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= ADDR_W'(FIRST_FREE)) |=> $stable(all_out));

   p_mode_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(0)) |=>
         (pat_sel == $past(wr_data[3:2]) && drv_code == $past(wr_data[1:0])));

   p_low_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(2)) |=> pd_mask[DATA_W-1:0] == $past(wr_data));

   p_first_nibble_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(PAT_BASE)) |=> cust_pat[DATA_W-1:0] == $past(wr_data));

endmodule

bind cfg_serial_port cfg_serial_port_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .NUM_CH (NUM_CH),
   .PAT_W  (PAT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .csn         (csn),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .pat_sel     (pat_sel),
   .drv_code    (drv_code),
   .msb_first   (msb_first),
   .clk_drv_dbl (clk_drv_dbl),
   .pd_mask     (pd_mask),
   .cust_pat    (cust_pat)
);

// File: tb/cfg_serial_port_test.sv
`timescale 1ns/1ps
module cfg_serial_port_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1;
   logic sclk = 1'b0;
   logic sdin = 1'b0;

   logic [1:0]  pat_sel;
   logic [1:0]  drv_code;
   logic        msb_first;
   logic        clk_drv_dbl;
   logic [7:0]  pd_mask;
   logic [11:0] cust_pat;

   int compared = 0;
   int mismatched = 0;

   // model: one nibble per address
   logic [3:0] m [0:15];

   always #4 clk = ~clk;

   cfg_serial_port uut (
      .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdin(sdin),
      .pat_sel(pat_sel), .drv_code(drv_code), .msb_first(msb_first),
      .clk_drv_dbl(clk_drv_dbl), .pd_mask(pd_mask), .cust_pat(cust_pat)
   );

   function automatic logic [25:0] expected();
      return {m[0][3:2], m[0][1:0], m[1][2], m[1][0], m[3], m[2], m[6], m[5], m[4]};
   endfunction

   task automatic check(input logic [25:0] exp, input string req);
      logic [25:0] act;
      act = {pat_sel, drv_code, msb_first, clk_drv_dbl, pd_mask, cust_pat};
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic shift_frame(input logic [7:0] w, input int nedges);
      @(negedge clk);
      csn = 1'b0;
      #20;
      for (int i = 0; i < nedges; i++) begin
         sdin = (i < 8) ? w[7-i] : 1'b0;
         #10 sclk = 1'b1;
         #30 sclk = 1'b0;
         #20;
      end
      #10;
   endtask

   // sends a frame and checks the outputs before and at the commit edge
   task automatic frame(input logic [7:0] w, input int nedges, input string req);
      logic [25:0] old_exp;
      old_exp = expected();
      shift_frame(w, nedges);
      @(negedge clk);
      csn = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1 check(old_exp, "R3");
      if (nedges == 8 && w[7:4] <= 4'd6) m[w[7:4]] = w[3:0];
      @(posedge clk);
      #1 check(expected(), req);
      repeat (6) @(negedge clk);
   endtask

   function automatic string req_of(input int a);
      if (a == 0) return "R6";
      if (a == 1) return "R7";
      if (a <= 3) return "R8";
      if (a <= 6) return "R9";
      return "R5";
   endfunction

   initial begin
      #1_000_000;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) m[i] = 4'h0;
      repeat (3) @(negedge clk);
      check(26'h0, "R1");              // R1: outputs clear in reset
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(26'h0, "R1");

      // R2: address 5 data A -> cust_pat[7:4] = A, bit order MSB first
      frame(8'h5A, 8, "R2");
      // R7: data bits 3 and 1 ignored
      frame(8'h1A, 8, "R7");
      // R4: short and long frames leave outputs alone
      frame(8'h2F, 7, "R4");
      frame(8'h2F, 9, "R4");
      frame(8'h63, 7, "R4");

      for (int a = 0; a < 16; a++)
         for (int d = 0; d < 16; d++)
            frame({4'(a), 4'(d)}, 8, req_of(a));

      // R1: reset in the middle of operation clears everything
      frame(8'h3C, 8, "R8");
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) m[i] = 4'h0;
      repeat (2) @(negedge clk);
      check(26'h0, "R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(26'h0, "R1");
      frame(8'h4B, 8, "R9");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule